// File: doc/BRIEF.md
# Packed-Decimal Adder/Subtractor with Sign-Magnitude Output

This block adds or subtracts two unsigned packed decimal operands of `NDIG` digits. Each digit is four bits in 8-4-2-1 weighting. The result is a decimal magnitude plus a sign bit. The block is purely combinational. A surrounding datapath drives the operands and the operation select, then reads the result in the same cycle.

Subtraction never uses a subtractor. Each digit of the subtrahend is turned into its nine's complement by inverting its four bits and adding binary 1010, keeping only the low four bits. A ripple of decimal digit adders then sums the minuend and the complemented subtrahend. Any digit whose binary sum exceeds nine is corrected by adding six, which also raises a carry into the next digit.

The carry out of the most significant digit decides what happens next:
- When that carry is set, the difference is non-negative. The carry is fed back into the least significant digit as an end-around carry.
- When that carry is clear, the sum is the nine's complement of a negative difference. A true/complement stage recomplements every digit, and the sign output is raised.

Top module: `bcd_addsub`

## Requirements
- R1: With `subtract` low, `result` equals (A + B) mod 10^NDIG, `sign` is 0, and `overflow` is 1 exactly when A + B is at least 10^NDIG.
- R2: Operands and result are packed: digit i occupies bits [4i+3:4i], and digit 0 (bits 3:0) is the least significant.
- R3: With `subtract` high and A > B, `result` equals A - B and `sign` is 0. Examples: 87-39 gives 48, and 65-12 gives 53.
- R4: With `subtract` high and A < B, `result` equals B - A and `sign` is 1. Examples: 03-08 gives 05 with sign 1, and 18-72 gives 54 with sign 1.
- R5: With `subtract` high and A = B, `result` is all zero digits and `sign` is 0. A negative zero is never produced.
- R6: When every input digit is in 0..9, every output digit is in 0..9.
- R7: With `subtract` high, `overflow` is 0.
- R8: The subtrahend digit complement equals 9 minus the digit. This can be seen at the ports: 0 - B yields magnitude B with sign 1 for any non-zero B.
- R9: Outputs respond to input changes without any clock. The result is valid in the same cycle in which the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4*NDIG | Minuend or first addend, packed decimal |
| opB | input | 4*NDIG | Subtrahend or second addend, packed decimal |
| subtract | input | 1 | 1 selects A - B, 0 selects A + B |
| result | output | 4*NDIG | Decimal magnitude of the result |
| sign | output | 1 | 1 when the difference is negative, 0 otherwise |
| overflow | output | 1 | Decimal carry out of the top digit during addition |

## Verification
The bound checker watches the properties that hold for every input: digit legality of the output, sign clear during addition, overflow clear during subtraction, no negative zero, and a zero result for equal operands. The arithmetic itself cannot be checked this way. That covers the end-around carry giving the exact difference, the recomplement giving the true magnitude, and the overflow threshold during addition. Only the bench's worked cases and its sweep over every two-digit operand pair, compared against integer arithmetic, can show these.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef logic [3:0] digit_t;

  // strobes that depend only on the operation select
  typedef struct packed {
    logic cplB;
  } preStrobe_t;

  // strobes that depend on the first-pass carry
  typedef struct packed {
    logic eacEn;
    logic recomp;
  } postStrobe_t;
endpackage

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_pkg::*;
(
  input  digit_t digIn,
  output digit_t digOut
);
  // inverted digit plus binary ten, carry out dropped
  assign digOut = (~digIn) + 4'b1010;
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_pkg::*;
(
  input  digit_t addA,
  input  digit_t addB,
  input  logic   carryIn,
  output digit_t sumOut,
  output logic   carryOut
);
  logic [4:0] rawSum;
  logic       needFix;

  always_comb begin
    rawSum   = {1'b0, addA} + {1'b0, addB} + {4'b0000, carryIn};
    needFix  = (rawSum > 5'd9);
    sumOut   = needFix ? (rawSum[3:0] + 4'd6) : rawSum[3:0];
    carryOut = needFix;
  end
endmodule

// File: rtl/bcd_datapath.sv
module bcd_datapath
  import bcd_pkg::*;
#(
  parameter int NDIG = 2
) (
  input  logic [4*NDIG-1:0] opA,
  input  logic [4*NDIG-1:0] opB,
  input  preStrobe_t        pre,
  input  postStrobe_t       post,
  output logic [4*NDIG-1:0] magnitude,
  output logic              firstCarry,
  output logic              sumAllNines
);
  localparam int W = 4 * NDIG;

  logic [W-1:0]  bSel;
  logic [W-1:0]  sum1;
  logic [W-1:0]  sum2;
  logic [W-1:0]  sum2Cpl;
  logic [NDIG:0] c1;
  logic [NDIG:0] c2;
  logic [NDIG-1:0] digNine;

  assign c1[0] = 1'b0;
  assign c2[0] = post.eacEn;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    digit_t bCpl;
    digit_t zeroDig;
    assign zeroDig = '0;

    bcd_nines u_cplB (
      .digIn  (opB[4*i +: 4]),
      .digOut (bCpl)
    );

    assign bSel[4*i +: 4] = pre.cplB ? bCpl : opB[4*i +: 4];

    bcd_digit_add u_add1 (
      .addA     (opA[4*i +: 4]),
      .addB     (bSel[4*i +: 4]),
      .carryIn  (c1[i]),
      .sumOut   (sum1[4*i +: 4]),
      .carryOut (c1[i+1])
    );

    assign digNine[i] = (sum1[4*i +: 4] == 4'd9);

    // end-around carry pass
    bcd_digit_add u_add2 (
      .addA     (sum1[4*i +: 4]),
      .addB     (zeroDig),
      .carryIn  (c2[i]),
      .sumOut   (sum2[4*i +: 4]),
      .carryOut (c2[i+1])
    );

    bcd_nines u_cplR (
      .digIn  (sum2[4*i +: 4]),
      .digOut (sum2Cpl[4*i +: 4])
    );
  end

  assign firstCarry  = c1[NDIG];
  assign sumAllNines = &digNine;
  assign magnitude   = post.recomp ? sum2Cpl : sum2;

  // the top carry of the second pass is never set on legal inputs
  logic unusedCarry;
  assign unusedCarry = c2[NDIG];
endmodule

// File: rtl/bcd_control.sv
module bcd_control
  import bcd_pkg::*;
(
  input  logic        subtract,
  input  logic        firstCarry,
  input  logic        sumAllNines,
  output preStrobe_t  pre,
  output postStrobe_t post,
  output logic        sign,
  output logic        overflow
);
  always_comb begin
    pre.cplB    = subtract;
    post.eacEn  = subtract & firstCarry;
    post.recomp = subtract & ~firstCarry;
    // an all-nines sum with no carry is minus zero: report it as plus
    sign        = subtract & ~firstCarry & ~sumAllNines;
    overflow    = ~subtract & firstCarry;
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int NDIG = 2
) (
  input  logic [4*NDIG-1:0] opA,
  input  logic [4*NDIG-1:0] opB,
  input  logic              subtract,
  output logic [4*NDIG-1:0] result,
  output logic              sign,
  output logic              overflow
);
  preStrobe_t  pre;
  postStrobe_t post;
  logic        firstCarry;
  logic        sumAllNines;

  bcd_control u_ctrl (
    .subtract    (subtract),
    .firstCarry  (firstCarry),
    .sumAllNines (sumAllNines),
    .pre         (pre),
    .post        (post),
    .sign        (sign),
    .overflow    (overflow)
  );

  bcd_datapath #(.NDIG(NDIG)) u_dp (
    .opA         (opA),
    .opB         (opB),
    .pre         (pre),
    .post        (post),
    .magnitude   (result),
    .firstCarry  (firstCarry),
    .sumAllNines (sumAllNines)
  );
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int NDIG = 2
) (
  input logic [4*NDIG-1:0] opA,
  input logic [4*NDIG-1:0] opB,
  input logic              subtract,
  input logic [4*NDIG-1:0] result,
  input logic              sign,
  input logic              overflow
);
  logic inLegal;

  always_comb begin
    inLegal = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (opA[4*i +: 4] > 4'd9 || opB[4*i +: 4] > 4'd9) inLegal = 1'b0;
    end
    for (int i = 0; i < NDIG; i++) begin
      // R6
      p_digit_legal_r6: assert (!inLegal || result[4*i +: 4] <= 4'd9);
    end
    // R1
    p_add_positive_r1: assert (subtract || !sign);
    // R7
    p_no_overflow_r7: assert (!subtract || !overflow);
    // R5
    p_no_minus_zero_r5: assert (!sign || result != '0);
    // R5
    p_equal_zero_r5: assert (!(subtract && inLegal && opA == opB) || (result == '0 && !sign));
  end
endmodule

bind bcd_addsub bcd_addsub_chk #(.NDIG(NDIG)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .subtract (subtract),
  .result   (result),
  .sign     (sign),
  .overflow (overflow)
);

// File: tb/sim_bcd_addsub.sv
module sim_bcd_addsub;
  localparam int NDIG = 2;
  localparam int W    = 4 * NDIG;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         subtract = 1'b0;
  logic [W-1:0] result;
  logic         sign;
  logic         overflow;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  bcd_addsub #(.NDIG(NDIG)) u0 (
    .opA      (opA),
    .opB      (opB),
    .subtract (subtract),
    .result   (result),
    .sign     (sign),
    .overflow (overflow)
  );

  function automatic logic [W-1:0] toDec(int v);
    logic [W-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < NDIG; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // fields: A, B, sub, result, sign, overflow (values in decimal digits)
  localparam logic [26:0] VEC [9] = '{
    {8'h08, 8'h03, 1'b1, 8'h05, 1'b0, 1'b0},
    {8'h03, 8'h08, 1'b1, 8'h05, 1'b1, 1'b0},
    {8'h87, 8'h39, 1'b1, 8'h48, 1'b0, 1'b0},
    {8'h18, 8'h72, 1'b1, 8'h54, 1'b1, 1'b0},
    {8'h65, 8'h12, 1'b1, 8'h53, 1'b0, 1'b0},
    {8'h99, 8'h01, 1'b0, 8'h00, 1'b0, 1'b1},
    {8'h45, 8'h54, 1'b0, 8'h99, 1'b0, 1'b0},
    {8'h00, 8'h99, 1'b1, 8'h99, 1'b1, 1'b0},
    {8'h50, 8'h50, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [W-1:0] expR, logic expS, logic expO);
    checks++;
    if (result !== expR || sign !== expS || overflow !== expO) begin
      failures++;
      $display("FAIL %s A=%h B=%h sub=%0b: got res=%h sign=%0b ovf=%0b, expected res=%h sign=%0b ovf=%0b",
               req, opA, opB, subtract, result, sign, overflow, expR, expS, expO);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic s);
    @(posedge clk);
    opA = a;
    opB = b;
    subtract = s;
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero inputs give zero outputs (R9)
    check("R9", '0, 1'b0, 1'b0);

    // worked cases (R1 R3 R4 R5 R8)
    for (int i = 0; i < 9; i++) begin
      apply(VEC[i][26:19], VEC[i][18:11], VEC[i][10]);
      check(VEC[i][10] ? "R3/R4/R5/R8" : "R1", VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R9: inputs change mid-cycle, output follows without a clock edge
    @(negedge clk);
    opA = 8'h27; opB = 8'h35; subtract = 1'b0;
    #1;
    check("R9", 8'h62, 1'b0, 1'b0);

    // R8: zero minus B yields B with sign set
    apply(8'h00, 8'h07, 1'b1);
    check("R8", 8'h07, 1'b1, 1'b0);

    // R2: digit placement, low digit only vs high digit only
    apply(8'h01, 8'h00, 1'b0);
    check("R2", 8'h01, 1'b0, 1'b0);
    apply(8'h10, 8'h00, 1'b0);
    check("R2", 8'h10, 1'b0, 1'b0);

    // exhaustive two-digit sweep (R1 R3 R4 R5 R6 R7)
    for (int a = 0; a < 100; a++) begin
      for (int b = 0; b < 100; b++) begin
        for (int s = 0; s < 2; s++) begin
          int d;
          apply(toDec(a), toDec(b), s[0]);
          if (s == 0) begin
            d = a + b;
            check("R1", toDec(d % 100), 1'b0, d >= 100);
          end else begin
            d = a - b;
            if (d > 0)       check("R3", toDec(d), 1'b0, 1'b0);
            else if (d == 0) check("R5", toDec(0), 1'b0, 1'b0);
            else             check("R4", toDec(-d), 1'b1, 1'b0);
          end
        end
      end
    end
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end
endmodule